// File: doc/BRIEF.md
# Keyed I/O-Window Configuration Decoder

This block sits between a host I/O port bus and a configuration request channel. It holds two 8-bit control registers in one I/O dword. The key register sits at port 0x0CF8 and the bus-select register at port 0x0CFA. When the upper nibble of the key register is 0xF, host accesses to the 4 KB I/O range 0xC000–0xCFFF become configuration requests. The function number comes from key register bits 3:1, and the bus number comes from the bus-select register. The device number comes from I/O address bits 11:8 and the register offset from address bits 7:0. The reachable space is therefore sixteen devices, eight functions each, with 256 bytes per function.

The host issues one access at a time as a single-cycle `io_req` pulse. It waits for the one-cycle `io_ack` before it issues the next access. Accesses that reach the two control registers, and accesses the block does not claim, complete in one cycle. A claimed window access raises `cfg_req` and holds it until the target returns `cfg_ack`. Software can probe the block by writing zeros to both registers and reading zeros back. Writing a zero key closes the window again.

Top module: `c2cfg_decoder`

## Requirements
- R1: After reset, the key register and the bus-select register both read as 0x00, so a full read of dword 0x0CF8 returns 0xFF00FF00.
- R2: A write to dword 0x0CF8 stores byte lane 0 into the key register and byte lane 2 into the bus-select register, each only when its `io_be` bit is set. A read returns both registers in those lanes and 0xFF in lanes 1 and 3.
- R3: With key nibble 0xF, a window access raises `cfg_req`. The request carries `cfg_bus` equal to the bus-select register, `cfg_fn` equal to key bits 3:1, `cfg_dev` equal to address bits 11:8, `cfg_reg` equal to address bits 7:2 followed by two zero bits, and the host's write flag and write data.
- R4: `cfg_req` and its fields stay stable until `cfg_ack` is sampled high. In the next cycle, `io_ack` rises, `cfg_req` falls, and for a read `io_rdata` holds `cfg_rdata`.
- R5: While the key nibble is not 0xF, window accesses raise no `cfg_req`. They are acknowledged in the next cycle, and reads return 0xFFFFFFFF.
- R6: Key bit 0 and key nibbles other than 0x0 and 0xF are stored and read back, but they have no decode effect. Bit 0 does not change `cfg_fn`, and any key other than 0xF keeps the window closed.
- R7: An access outside both dword 0x0CF8 and the window raises no `cfg_req` and reads as 0xFFFFFFFF.
- R8: Byte, halfword and dword accesses in the window are all forwarded. `cfg_be` equals `io_be` unchanged.
- R9: Accesses to the control registers and unclaimed accesses raise `io_ack` exactly one cycle after `io_req`.
- R10: Writing 0x00 to the key register closes an open window, so the next window access is not claimed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_req | input | 1 | Single-cycle host access strobe |
| io_wr | input | 1 | 1 = write, 0 = read |
| io_addr | input | 16 | I/O byte address |
| io_be | input | 4 | Byte lane enables of the addressed dword |
| io_wdata | input | 32 | Host write data |
| io_ack | output | 1 | One-cycle completion pulse |
| io_rdata | output | 32 | Host read data, valid with io_ack |
| cfg_req | output | 1 | Configuration request, held until acknowledged |
| cfg_wr | output | 1 | Configuration write flag |
| cfg_bus | output | 8 | Target bus number |
| cfg_dev | output | 4 | Target device number |
| cfg_fn | output | 3 | Target function number |
| cfg_reg | output | 8 | Dword-aligned register offset |
| cfg_be | output | 4 | Byte enables of the configuration access |
| cfg_wdata | output | 32 | Configuration write data |
| cfg_ack | input | 1 | Target completion strobe |
| cfg_rdata | input | 32 | Target read data, valid with cfg_ack |

## Verification
The bench sets key bit 0 to catch a design that takes the function number from bits 2:0, which would send requests to the wrong function. It tries a non-0xF key and a zeroed key, and a decoder that tests only part of the nibble would still issue requests there. Partial byte-enable writes to the control dword catch a design that writes both registers on any write and so corrupts the bus number. Halfword and byte window accesses at unaligned addresses expose a design that alters the enables or leaks the low address bits into the register offset. A slowed target shows whether a design drops the request early or completes the host access before the target responds.

// File: rtl/c2cfg_pkg.sv
package c2cfg_pkg;

  localparam int DATA_W = 32;
  localparam int BE_W   = DATA_W / 8;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    HIT_NONE   = 2'd0,
    HIT_CTRL   = 2'd1,
    HIT_WINDOW = 2'd2
  } hit_t;

  typedef enum logic [0:0] {
    SEQ_IDLE = 1'b0,
    SEQ_WAIT = 1'b1
  } seq_state_t;

endpackage

// File: rtl/c2_addr_decode.sv
module c2_addr_decode #(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] CTRL_DW  = 16'h0CF8,
  parameter logic [3:0]  WIN_NIB  = 4'hC,
  parameter int          DEV_W    = 4
) (
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  window_open,
  output c2cfg_pkg::hit_t       hit,
  output logic [DEV_W-1:0]      dev,
  output logic [5:0]            dw_idx
);
  import c2cfg_pkg::*;

  localparam int NIB_LO = ADDR_W - 4;
  localparam int DEV_LO = 8;

  logic in_ctrl;
  logic in_window;

  assign in_ctrl   = (addr[ADDR_W-1:2] == CTRL_DW[ADDR_W-1:2]);
  assign in_window = (addr[ADDR_W-1:NIB_LO] == WIN_NIB);

  always_comb begin
    if (in_ctrl)                        hit = HIT_CTRL;
    else if (in_window && window_open)  hit = HIT_WINDOW;
    else                                hit = HIT_NONE;
  end

  assign dev    = addr[DEV_LO +: DEV_W];
  assign dw_idx = addr[7:2];

endmodule

// File: rtl/c2_key_regs.sv
module c2_key_regs #(
  parameter logic [15:0] KEY_PORT = 16'h0CF8,
  parameter logic [15:0] BUS_PORT = 16'h0CFA,
  parameter logic [3:0]  KEY_ON   = 4'hF
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [c2cfg_pkg::BE_W-1:0]    be,
  input  logic [c2cfg_pkg::DATA_W-1:0]  wdata,
  output logic [7:0]                    key_q,
  output logic [7:0]                    bus_q,
  output logic                          window_open,
  output logic [c2cfg_pkg::DATA_W-1:0]  rd_word
);
  import c2cfg_pkg::*;

  localparam int KEY_LANE = int'(KEY_PORT[1:0]);
  localparam int BUS_LANE = int'(BUS_PORT[1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      key_q <= '0;
      bus_q <= '0;
    end else if (wr_en) begin
      if (be[KEY_LANE]) key_q <= wdata[KEY_LANE*BYTE_W +: BYTE_W];
      if (be[BUS_LANE]) bus_q <= wdata[BUS_LANE*BYTE_W +: BYTE_W];
    end
  end

  assign window_open = (key_q[7:4] == KEY_ON);

  for (genvar ln = 0; ln < BE_W; ln++) begin : g_lane
    if (ln == KEY_LANE) begin : g_key
      assign rd_word[ln*BYTE_W +: BYTE_W] = key_q;
    end else if (ln == BUS_LANE) begin : g_bus
      assign rd_word[ln*BYTE_W +: BYTE_W] = bus_q;
    end else begin : g_idle
      assign rd_word[ln*BYTE_W +: BYTE_W] = {BYTE_W{1'b1}};
    end
  end

endmodule

// File: rtl/c2_cycle_seq.sv
module c2_cycle_seq #(
  parameter int DEV_W = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          io_req,
  input  logic                          io_wr,
  input  logic [c2cfg_pkg::BE_W-1:0]    io_be,
  input  logic [c2cfg_pkg::DATA_W-1:0]  io_wdata,
  input  c2cfg_pkg::hit_t               hit,
  input  logic [DEV_W-1:0]              dev,
  input  logic [5:0]                    dw_idx,
  input  logic [7:0]                    bus_sel,
  input  logic [2:0]                    fn_sel,
  input  logic [c2cfg_pkg::DATA_W-1:0]  ctrl_rdata,
  input  logic                          cfg_ack,
  input  logic [c2cfg_pkg::DATA_W-1:0]  cfg_rdata,
  output logic                          io_ack,
  output logic [c2cfg_pkg::DATA_W-1:0]  io_rdata,
  output logic                          cfg_req,
  output logic                          cfg_wr,
  output logic [7:0]                    cfg_bus,
  output logic [DEV_W-1:0]              cfg_dev,
  output logic [2:0]                    cfg_fn,
  output logic [7:0]                    cfg_reg,
  output logic [c2cfg_pkg::BE_W-1:0]    cfg_be,
  output logic [c2cfg_pkg::DATA_W-1:0]  cfg_wdata
);
  import c2cfg_pkg::*;

  seq_state_t st_q;
  logic       rd_pending_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= SEQ_IDLE;
      io_ack       <= 1'b0;
      io_rdata     <= '0;
      cfg_req      <= 1'b0;
      cfg_wr       <= 1'b0;
      cfg_bus      <= '0;
      cfg_dev      <= '0;
      cfg_fn       <= '0;
      cfg_reg      <= '0;
      cfg_be       <= '0;
      cfg_wdata    <= '0;
      rd_pending_q <= 1'b0;
    end else begin
      io_ack <= 1'b0;
      unique case (st_q)
        SEQ_IDLE: begin
          if (io_req) begin
            if (hit == HIT_WINDOW) begin
              cfg_req      <= 1'b1;
              cfg_wr       <= io_wr;
              cfg_bus      <= bus_sel;
              cfg_dev      <= dev;
              cfg_fn       <= fn_sel;
              cfg_reg      <= {dw_idx, 2'b00};
              cfg_be       <= io_be;
              cfg_wdata    <= io_wdata;
              rd_pending_q <= !io_wr;
              st_q         <= SEQ_WAIT;
            end else begin
              io_ack <= 1'b1;
              if (io_wr)                io_rdata <= '0;
              else if (hit == HIT_CTRL) io_rdata <= ctrl_rdata;
              else                      io_rdata <= '1;
            end
          end
        end
        SEQ_WAIT: begin
          if (cfg_ack) begin
            cfg_req  <= 1'b0;
            io_ack   <= 1'b1;
            io_rdata <= rd_pending_q ? cfg_rdata : '0;
            st_q     <= SEQ_IDLE;
          end
        end
        default: st_q <= SEQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/c2cfg_decoder.sv
module c2cfg_decoder #(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] KEY_PORT = 16'h0CF8,
  parameter logic [15:0] BUS_PORT = 16'h0CFA,
  parameter logic [3:0]  WIN_NIB  = 4'hC,
  parameter logic [3:0]  KEY_ON   = 4'hF
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 io_req,
  input  logic                 io_wr,
  input  logic [ADDR_W-1:0]    io_addr,
  input  logic [3:0]           io_be,
  input  logic [31:0]          io_wdata,
  output logic                 io_ack,
  output logic [31:0]          io_rdata,
  output logic                 cfg_req,
  output logic                 cfg_wr,
  output logic [7:0]           cfg_bus,
  output logic [3:0]           cfg_dev,
  output logic [2:0]           cfg_fn,
  output logic [7:0]           cfg_reg,
  output logic [3:0]           cfg_be,
  output logic [31:0]          cfg_wdata,
  input  logic                 cfg_ack,
  input  logic [31:0]          cfg_rdata
);
  import c2cfg_pkg::*;

  localparam int DEV_W = 4;

  hit_t               hit;
  logic [DEV_W-1:0]   dec_dev;
  logic [5:0]         dec_dw;
  logic [7:0]         key_q;
  logic [7:0]         bus_q;
  logic               window_open;
  logic [DATA_W-1:0]  ctrl_word;
  logic               ctrl_wr;

  c2_addr_decode #(
    .ADDR_W  (ADDR_W),
    .CTRL_DW (KEY_PORT),
    .WIN_NIB (WIN_NIB),
    .DEV_W   (DEV_W)
  ) u_dec (
    .addr        (io_addr),
    .window_open (window_open),
    .hit         (hit),
    .dev         (dec_dev),
    .dw_idx      (dec_dw)
  );

  assign ctrl_wr = io_req && io_wr && (hit == HIT_CTRL);

  c2_key_regs #(
    .KEY_PORT (KEY_PORT),
    .BUS_PORT (BUS_PORT),
    .KEY_ON   (KEY_ON)
  ) u_regs (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (ctrl_wr),
    .be          (io_be),
    .wdata       (io_wdata),
    .key_q       (key_q),
    .bus_q       (bus_q),
    .window_open (window_open),
    .rd_word     (ctrl_word)
  );

  c2_cycle_seq #(
    .DEV_W (DEV_W)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .io_req     (io_req),
    .io_wr      (io_wr),
    .io_be      (io_be),
    .io_wdata   (io_wdata),
    .hit        (hit),
    .dev        (dec_dev),
    .dw_idx     (dec_dw),
    .bus_sel    (bus_q),
    .fn_sel     (key_q[3:1]),
    .ctrl_rdata (ctrl_word),
    .cfg_ack    (cfg_ack),
    .cfg_rdata  (cfg_rdata),
    .io_ack     (io_ack),
    .io_rdata   (io_rdata),
    .cfg_req    (cfg_req),
    .cfg_wr     (cfg_wr),
    .cfg_bus    (cfg_bus),
    .cfg_dev    (cfg_dev),
    .cfg_fn     (cfg_fn),
    .cfg_reg    (cfg_reg),
    .cfg_be     (cfg_be),
    .cfg_wdata  (cfg_wdata)
  );

endmodule

// File: rtl/c2cfg_checker.sv
module c2cfg_checker (
  input logic        clk,
  input logic        rst,
  input logic        io_req,
  input logic [15:0] io_addr,
  input logic [3:0]  io_be,
  input logic        io_ack,
  input logic        cfg_req,
  input logic        cfg_ack,
  input logic [7:0]  cfg_bus,
  input logic [3:0]  cfg_dev,
  input logic [2:0]  cfg_fn,
  input logic [7:0]  cfg_reg,
  input logic [3:0]  cfg_be,
  input logic [7:0]  key_q,
  input logic [7:0]  bus_q
);

  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  always_ff @(posedge clk) begin
    if (rst_d && !rst) begin
      p_reset_clear_r1: assert (key_q == 8'h00 && bus_q == 8'h00)
        else $error("control registers not cleared by reset");
    end
  end

  p_fields_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_req) |-> (cfg_bus == $past(bus_q)) && (cfg_fn == $past(key_q[3:1]))
                       && (cfg_dev == $past(io_addr[11:8])) && (cfg_reg[1:0] == 2'b00))
    else $error("request fields do not match registers and address");

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (cfg_req && !cfg_ack) |=> cfg_req && $stable(cfg_dev) && $stable(cfg_reg) && $stable(cfg_be))
    else $error("request dropped or changed before acknowledge");

  p_complete_r4: assert property (@(posedge clk) disable iff (rst)
    (cfg_req && cfg_ack) |=> io_ack && !cfg_req)
    else $error("host not acknowledged after target acknowledge");

  p_locked_r5: assert property (@(posedge clk) disable iff (rst)
    (io_req && !cfg_req && key_q[7:4] != 4'hF) |=> !cfg_req && io_ack)
    else $error("request issued while key is not 0xF");

  p_outside_r7: assert property (@(posedge clk) disable iff (rst)
    (io_req && !cfg_req && io_addr[15:12] != 4'hC) |=> !cfg_req && io_ack)
    else $error("access outside the window claimed");

  p_be_pass_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_req) |-> cfg_be == $past(io_be))
    else $error("byte enables altered");

endmodule

bind c2cfg_decoder c2cfg_checker u_chk (
  .clk     (clk),
  .rst     (rst),
  .io_req  (io_req),
  .io_addr (io_addr),
  .io_be   (io_be),
  .io_ack  (io_ack),
  .cfg_req (cfg_req),
  .cfg_ack (cfg_ack),
  .cfg_bus (cfg_bus),
  .cfg_dev (cfg_dev),
  .cfg_fn  (cfg_fn),
  .cfg_reg (cfg_reg),
  .cfg_be  (cfg_be),
  .key_q   (key_q),
  .bus_q   (bus_q)
);

// File: tb/sim_c2cfg_decoder.sv
module sim_c2cfg_decoder;

  localparam int CLK_PERIOD = 10;
  localparam int TGT_DLY    = 2;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        io_req = 1'b0;
  logic        io_wr = 1'b0;
  logic [15:0] io_addr = '0;
  logic [3:0]  io_be = '0;
  logic [31:0] io_wdata = '0;
  logic        io_ack;
  logic [31:0] io_rdata;
  logic        cfg_req;
  logic        cfg_wr;
  logic [7:0]  cfg_bus;
  logic [3:0]  cfg_dev;
  logic [2:0]  cfg_fn;
  logic [7:0]  cfg_reg;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata;
  logic        cfg_ack = 1'b0;
  logic [31:0] cfg_rdata = '0;

  int checks = 0;
  int fails  = 0;

  int          tgt_count = 0;
  int          tgt_wait  = 0;
  logic        cap_wr;
  logic [7:0]  cap_bus;
  logic [3:0]  cap_dev;
  logic [2:0]  cap_fn;
  logic [7:0]  cap_reg;
  logic [3:0]  cap_be;
  logic [31:0] cap_wdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  c2cfg_decoder u0 (
    .clk(clk), .rst(rst), .io_req(io_req), .io_wr(io_wr), .io_addr(io_addr),
    .io_be(io_be), .io_wdata(io_wdata), .io_ack(io_ack), .io_rdata(io_rdata),
    .cfg_req(cfg_req), .cfg_wr(cfg_wr), .cfg_bus(cfg_bus), .cfg_dev(cfg_dev),
    .cfg_fn(cfg_fn), .cfg_reg(cfg_reg), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_ack(cfg_ack), .cfg_rdata(cfg_rdata)
  );

  function automatic logic [31:0] tgt_data(logic [7:0] b, logic [3:0] d, logic [2:0] f, logic [7:0] r);
    return {b, 4'h0, d, 5'h0, f, r};
  endfunction

  // Target model: acknowledges TGT_DLY negedges after it first sees a request.
  always @(negedge clk) begin
    if (cfg_ack) begin
      cfg_ack  = 1'b0;
      tgt_wait = 0;
    end else if (cfg_req) begin
      tgt_wait++;
      if (tgt_wait == TGT_DLY) begin
        cfg_ack   = 1'b1;
        cfg_rdata = tgt_data(cfg_bus, cfg_dev, cfg_fn, cfg_reg);
        cap_wr    = cfg_wr;
        cap_bus   = cfg_bus;
        cap_dev   = cfg_dev;
        cap_fn    = cfg_fn;
        cap_reg   = cfg_reg;
        cap_be    = cfg_be;
        cap_wdata = cfg_wdata;
        tgt_count++;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic io_xfer(input logic wr, input logic [15:0] addr, input logic [3:0] be,
                         input logic [31:0] wd, output logic [31:0] rd, output int lat);
    io_req   = 1'b1;
    io_wr    = wr;
    io_addr  = addr;
    io_be    = be;
    io_wdata = wd;
    @(negedge clk);
    io_req = 1'b0;
    lat = 1;
    while (!io_ack) begin
      @(negedge clk);
      lat++;
    end
    rd = io_rdata;
    @(negedge clk);
  endtask

  task automatic t_reset_state;
    logic [31:0] rd; int lat;
    io_xfer(1'b0, 16'h0CF8, 4'hF, '0, rd, lat);
    chk("R1", rd, 32'hFF00FF00);
    chk("R9", lat, 1);
  endtask

  task automatic t_ctrl_regs;
    logic [31:0] rd; int lat;
    io_xfer(1'b1, 16'h0CF8, 4'b0101, 32'h0037_00F2, rd, lat);
    chk("R9", lat, 1);
    io_xfer(1'b0, 16'h0CF8, 4'hF, '0, rd, lat);
    chk("R2", rd, 32'hFF37FFF2);
    io_xfer(1'b1, 16'h0CFA, 4'b0100, 32'h0011_00AA, rd, lat);
    io_xfer(1'b0, 16'h0CF8, 4'hF, '0, rd, lat);
    chk("R2", rd, 32'hFF11FFF2);
  endtask

  task automatic t_window_read;
    logic [31:0] rd; int lat; int n0;
    n0 = tgt_count;
    io_xfer(1'b0, 16'hC540, 4'hF, '0, rd, lat);
    chk("R3", tgt_count - n0, 1);
    chk("R3", {cap_bus, cap_dev, 1'b0, cap_fn, cap_reg, 7'h0, cap_wr}, {8'h11, 4'h5, 1'b0, 3'd1, 8'h40, 8'h00});
    chk("R4", rd, tgt_data(8'h11, 4'h5, 3'd1, 8'h40));
    chk("R4", lat, TGT_DLY + 1);
  endtask

  task automatic t_window_sizes;
    logic [31:0] rd; int lat;
    io_xfer(1'b1, 16'hC7A6, 4'b1100, 32'hBEEF_0000, rd, lat);
    chk("R8", cap_be, 4'b1100);
    chk("R3", {cap_wr, 3'b0, cap_dev, cap_reg}, {1'b1, 3'b0, 4'h7, 8'hA4});
    chk("R3", cap_wdata, 32'hBEEF_0000);
    io_xfer(1'b0, 16'hC30D, 4'b0010, '0, rd, lat);
    chk("R8", {cap_be, cap_reg}, {4'b0010, 8'h0C});
    chk("R8", rd, tgt_data(8'h11, 4'h3, 3'd1, 8'h0C));
  endtask

  task automatic t_bit0;
    logic [31:0] rd; int lat;
    io_xfer(1'b1, 16'h0CF8, 4'b0001, 32'h0000_00F5, rd, lat);
    io_xfer(1'b0, 16'h0CF8, 4'hF, '0, rd, lat);
    chk("R6", rd, 32'hFF11FFF5);
    io_xfer(1'b0, 16'hC000, 4'hF, '0, rd, lat);
    chk("R6", cap_fn, 3'd2);
  endtask

  task automatic t_locked;
    logic [31:0] rd; int lat; int n0;
    io_xfer(1'b1, 16'h0CF8, 4'b0001, 32'h0000_00A7, rd, lat);
    n0 = tgt_count;
    io_xfer(1'b0, 16'hC540, 4'hF, '0, rd, lat);
    chk("R5", rd, 32'hFFFFFFFF);
    chk("R5", tgt_count - n0, 0);
    chk("R9", lat, 1);
    io_xfer(1'b0, 16'h0CF8, 4'hF, '0, rd, lat);
    chk("R6", rd, 32'hFF11FFA7);
  endtask

  task automatic t_disable;
    logic [31:0] rd; int lat; int n0;
    io_xfer(1'b1, 16'h0CF8, 4'b0001, 32'h0000_00F0, rd, lat);
    n0 = tgt_count;
    io_xfer(1'b0, 16'hCF04, 4'hF, '0, rd, lat);
    chk("R10", tgt_count - n0, 1);
    io_xfer(1'b1, 16'h0CF8, 4'b0001, 32'h0, rd, lat);
    n0 = tgt_count;
    io_xfer(1'b0, 16'hCF04, 4'hF, '0, rd, lat);
    chk("R10", tgt_count - n0, 0);
    chk("R10", rd, 32'hFFFFFFFF);
  endtask

  task automatic t_outside;
    logic [31:0] rd; int lat; int n0;
    io_xfer(1'b1, 16'h0CF8, 4'b0001, 32'h0000_00F0, rd, lat);
    n0 = tgt_count;
    io_xfer(1'b0, 16'h1234, 4'hF, '0, rd, lat);
    chk("R7", rd, 32'hFFFFFFFF);
    chk("R7", tgt_count - n0, 0);
    chk("R9", lat, 1);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=<%0d cycles", WATCHDOG, WATCHDOG);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_ctrl_regs();
    t_window_read();
    t_window_sizes();
    t_bit0();
    t_locked();
    t_disable();
    t_outside();
    finish_run();
  end

endmodule